// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Input Capture Controller

This block sits beside a digital input port. It watches one external edge pin and one external block pin. When a qualifying edge arrives, the block can raise a host interrupt request, copy the current input-port word into a holding register, or do both. Four control bits choose the behaviour. Two bits govern the interrupt: an enable and a polarity. Two bits govern the capture: an enable and a polarity. Because each path has its own polarity bit, one shared edge pin can trigger both actions on the same transition or on opposite transitions.

Every edge that produces either action sets a sticky pending flag. Software clears the flag with a one-cycle clear strobe. The interrupt request is a level output. It stays asserted while the interrupt enable is set and the pending state was caused by an interrupt action.

Both external pins pass through a synchronizer before edge detection. An action therefore takes effect a fixed number of clock cycles after the pin changes.

Top module: `edge_latch_irq_ctrl`

## Requirements
- R1: While rst_ni is low, irq_o is 0, pending_o is 0 and latch_data_o is all zeros.
- R2: An edge produces an interrupt action only when irq_en_i is 1.
- R3: irq_pol_i = 0 selects the rising edge of edge_pin_i for the interrupt action, and irq_pol_i = 1 selects the falling edge.
- R4: When lat_en_i is 0, no edge captures data, and latch_data_o keeps its value.
- R5: lat_pol_i = 0 captures port_data_i on a rising edge of edge_pin_i, and lat_pol_i = 1 captures on a falling edge. This choice is independent of irq_pol_i.
- R6: While block_i is 1 (as seen after synchronization), edges on edge_pin_i produce no interrupt, no capture and no change to pending_o, whatever the control bits are.
- R7: pending_o sets on any edge that produces an interrupt action, a capture action or both. An edge that produces neither leaves pending_o unchanged.
- R8: A 1 on pend_clr_i clears pending_o on the next clock. If a new action occurs in the same cycle, the set wins and pending_o stays 1.
- R9: irq_o equals irq_en_i AND an internal flag. The flag is set by an interrupt action and cleared by pend_clr_i unless an interrupt action occurs in the same cycle. So irq_o falls after a clear, or when irq_en_i drops.
- R10: A change on edge_pin_i that is set up before rising clock edge k takes effect at rising edge k+2: pending_o, irq_o and latch_data_o change then. Each pin transition is acted on once.
- R11: latch_data_o holds the captured word until the next capture action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| edge_pin_i | input | 1 | External trigger pin, asynchronous |
| block_i | input | 1 | External pin; 1 ignores the trigger pin, asynchronous |
| port_data_i | input | DATA_W | Input port word to capture |
| irq_en_i | input | 1 | Interrupt enable control bit |
| irq_pol_i | input | 1 | Interrupt edge: 0 rising, 1 falling |
| lat_en_i | input | 1 | Capture enable control bit |
| lat_pol_i | input | 1 | Capture edge: 0 rising, 1 falling |
| pend_clr_i | input | 1 | Pending clear strobe, write-1-to-clear |
| irq_o | output | 1 | Interrupt request level |
| pending_o | output | 1 | Sticky pending status |
| latch_data_o | output | DATA_W | Captured port word |

## Verification
The bench sweeps all sixteen combinations of the four control bits. Each combination gets a rising edge and then a falling edge. This separates the two polarity paths and shows where they agree and where they disagree. The same sweep is repeated with the block pin high, to show that gating overrides every setting. The clear strobe is moved through each cycle offset around an edge, which exposes the set-over-clear priority and the exact three-stage latency. Narrow pin pulses and a drop of the interrupt enable while a request is pending finish the run. A behavioural queue model is compared with every output on every clock.

// File: rtl/eli_pkg.sv
package eli_pkg;

  typedef struct packed {
    logic irq_en;
    logic irq_pol;
    logic lat_en;
    logic lat_pol;
  } eli_ctrl_t;

  // pol = 0 selects rising, pol = 1 selects falling
  function automatic logic edge_sel(input logic pol, input logic rise, input logic fall);
    return pol ? fall : rise;
  endfunction

endpackage

// File: rtl/eli_sync.sv
module eli_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eli_edge_det.sv
module eli_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/eli_action_dec.sv
module eli_action_dec
  import eli_pkg::*;
(
  input  eli_ctrl_t ctrl_i,
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      blocked_i,
  output logic      irq_act_o,
  output logic      cap_act_o
);

  always_comb begin
    irq_act_o = 1'b0;
    cap_act_o = 1'b0;
    if (!blocked_i) begin
      irq_act_o = ctrl_i.irq_en & edge_sel(ctrl_i.irq_pol, rise_i, fall_i);
      cap_act_o = ctrl_i.lat_en & edge_sel(ctrl_i.lat_pol, rise_i, fall_i);
    end
  end

endmodule

// File: rtl/eli_status.sv
module eli_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_act_i,
  input  logic cap_act_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic pending_o,
  output logic irq_o
);

  logic pend_q;
  logic irq_src_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      irq_src_q <= 1'b0;
    end else begin
      if (irq_act_i | cap_act_i) pend_q <= 1'b1;
      else if (clr_i)            pend_q <= 1'b0;
      if (irq_act_i)             irq_src_q <= 1'b1;
      else if (clr_i)            irq_src_q <= 1'b0;
    end
  end

  assign pending_o = pend_q;
  assign irq_o     = irq_en_i & irq_src_q;

endmodule

// File: rtl/eli_capture.sv
module eli_capture #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= data_i;
  end

  assign data_o = hold_q;

endmodule

// File: rtl/edge_latch_irq_ctrl.sv
module edge_latch_irq_ctrl
  import eli_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_pin_i,
  input  logic              block_i,
  input  logic [DATA_W-1:0] port_data_i,
  input  logic              irq_en_i,
  input  logic              irq_pol_i,
  input  logic              lat_en_i,
  input  logic              lat_pol_i,
  input  logic              pend_clr_i,
  output logic              irq_o,
  output logic              pending_o,
  output logic [DATA_W-1:0] latch_data_o
);

  localparam int unsigned NSYNC = 2;

  logic [NSYNC-1:0] pins_async, pins_sync;
  logic             edge_s, block_s;
  logic             rise, fall;
  logic             irq_act, cap_act;
  eli_ctrl_t        ctrl;

  assign pins_async = {block_i, edge_pin_i};
  assign edge_s     = pins_sync[0];
  assign block_s    = pins_sync[1];
  assign ctrl       = '{irq_en: irq_en_i, irq_pol: irq_pol_i,
                        lat_en: lat_en_i, lat_pol: lat_pol_i};

  eli_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_async),
    .q_o   (pins_sync)
  );

  eli_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (edge_s),
    .rise_o(rise),
    .fall_o(fall)
  );

  eli_action_dec u_dec (
    .ctrl_i   (ctrl),
    .rise_i   (rise),
    .fall_i   (fall),
    .blocked_i(block_s),
    .irq_act_o(irq_act),
    .cap_act_o(cap_act)
  );

  eli_status u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_act_i(irq_act),
    .cap_act_i(cap_act),
    .clr_i    (pend_clr_i),
    .irq_en_i (irq_en_i),
    .pending_o(pending_o),
    .irq_o    (irq_o)
  );

  eli_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap_act),
    .data_i(port_data_i),
    .data_o(latch_data_o)
  );

endmodule

// File: rtl/edge_latch_irq_chk.sv
module edge_latch_irq_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_en_i,
  input logic              pend_clr_i,
  input logic              irq_o,
  input logic              pending_o,
  input logic [DATA_W-1:0] latch_data_o,
  input logic [DATA_W-1:0] port_data_i,
  input logic              block_s,
  input logic              irq_act,
  input logic              cap_act
);

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i); // R2

  AST_IRQ_IMPLIES_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pending_o); // R9

  AST_BLOCK_NO_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_s |-> !(irq_act || cap_act)); // R6

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_act || cap_act) |=> pending_o); // R7

  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr_i && !irq_act && !cap_act) |=> !pending_o); // R8

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_act |=> $stable(latch_data_o)); // R11

  AST_DATA_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_act |=> latch_data_o == $past(port_data_i)); // R5

endmodule

bind edge_latch_irq_ctrl edge_latch_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_en_i    (irq_en_i),
  .pend_clr_i  (pend_clr_i),
  .irq_o       (irq_o),
  .pending_o   (pending_o),
  .latch_data_o(latch_data_o),
  .port_data_i (port_data_i),
  .block_s     (block_s),
  .irq_act     (irq_act),
  .cap_act     (cap_act)
);

// File: tb/edge_latch_irq_ctrl_tb.sv
module edge_latch_irq_ctrl_tb;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          edge_pin = 1'b0, blk = 1'b0;
  logic [DW-1:0] pdata = '0;
  logic          irq_en = 0, irq_pol = 0, lat_en = 0, lat_pol = 0, clr = 0;
  logic          irq, pend;
  logic [DW-1:0] ldata;

  int    n_chk = 0, n_fail = 0, cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  bit          q_e[$], q_g[$];
  bit          m_pend, m_isrc;
  logic [DW-1:0] m_data;

  always #10 clk = ~clk;

  edge_latch_irq_ctrl #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .edge_pin_i(edge_pin), .block_i(blk),
    .port_data_i(pdata), .irq_en_i(irq_en), .irq_pol_i(irq_pol),
    .lat_en_i(lat_en), .lat_pol_i(lat_pol), .pend_clr_i(clr),
    .irq_o(irq), .pending_o(pend), .latch_data_o(ldata)
  );

  // pin value acts two samples after it is seen at a clock edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q_e = {0, 0, 0}; q_g = {0, 0, 0};
      m_pend = 0; m_isrc = 0; m_data = '0;
    end else begin
      bit en, eo, g, hi, hc;
      int n;
      q_e.push_back(edge_pin); q_g.push_back(blk);
      n  = q_e.size();
      en = q_e[n-3]; eo = q_e[n-4]; g = q_g[n-3];
      hi = !g && irq_en && (irq_pol ? (!en && eo) : (en && !eo));
      hc = !g && lat_en && (lat_pol ? (!en && eo) : (en && !eo));
      if (hi || hc) m_pend = 1; else if (clr) m_pend = 0;
      if (hi) m_isrc = 1; else if (clr) m_isrc = 0;
      if (hc) m_data = pdata;
      void'(q_e.pop_front()); void'(q_g.pop_front());
    end
    #5;
    if (rst_n && !done) begin
      check(irq, irq_en & m_isrc, "irq_o");
      check(pend, m_pend, "pending_o");
      check(ldata, m_data, "latch_data_o");
    end
  end

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr;
    clr = 1; step(1); clr = 0;
  endtask

  task automatic move_pin(input logic v);
    edge_pin = v; pdata = pdata * 32'd1103515245 + 32'd12345; step(6);
  endtask

  initial begin
    step(3);
    cur_req = "R1";
    check(irq, 0, "irq_o reset");
    check(pend, 0, "pending_o reset");
    check(ldata, 0, "latch_data_o reset");
    @(negedge clk); rst_n = 1; step(3);

    // explicit latency: rising edge, all enables
    cur_req = "R10";
    irq_en = 1; lat_en = 1; pdata = 32'hA5A5_0001;
    edge_pin = 1; step(2);
    check(pend, 0, "pending before latency");
    step(1);
    check(pend, 1, "pending after latency");
    check(ldata, 32'hA5A5_0001, "captured word");
    step(4); pulse_clr; step(2);

    // full control sweep, rising then falling
    cur_req = "R2 R3 R4 R5 R7 R11";
    for (int c = 0; c < 16; c++) begin
      {irq_en, irq_pol, lat_en, lat_pol} = 4'(c);
      pulse_clr; step(1);
      move_pin(0); pulse_clr; step(1);
      move_pin(1); pulse_clr; step(1);
      move_pin(0);
    end

    // gating overrides every setting
    cur_req = "R6";
    blk = 1; step(4);
    for (int c = 0; c < 16; c++) begin
      {irq_en, irq_pol, lat_en, lat_pol} = 4'(c);
      pulse_clr;
      move_pin(1); move_pin(0);
    end
    blk = 0; step(4);

    // clear at each offset around an edge
    cur_req = "R8 R9";
    {irq_en, irq_pol, lat_en, lat_pol} = 4'b1010;
    for (int off = 0; off < 6; off++) begin
      edge_pin = ~edge_pin; pdata = pdata + 32'd7;
      step(off); pulse_clr; step(8);
      pulse_clr; step(2);
    end

    // irq enable dropped while pending
    cur_req = "R9";
    {irq_en, irq_pol, lat_en, lat_pol} = 4'b1000;
    move_pin(~edge_pin); move_pin(~edge_pin);
    irq_en = 0; step(3); irq_en = 1; step(3); pulse_clr; step(3);

    // narrow pulses, each transition acted once
    cur_req = "R10";
    {irq_en, irq_pol, lat_en, lat_pol} = 4'b1011;
    for (int w = 1; w < 4; w++) begin
      edge_pin = ~edge_pin; pdata = pdata ^ 32'h0F0F_1234;
      step(w);
      edge_pin = ~edge_pin; pdata = pdata + 32'd3;
      step(8); pulse_clr; step(2);
    end

    step(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule